// File: doc/BRIEF.md
# Sequential Multiply, Divide and Modulo Unit

This unit executes the long-latency arithmetic group of a 32-bit RISC core: plain multiply (signed and unsigned), multiply in 16.16 signed fixed point, divide and remainder (signed and unsigned), and divide in 16.16 signed fixed point. The core presents a 4-bit opcode, the first operand and a one-cycle start pulse. It also supplies the second operand, either from the register file or as a 16-bit immediate. The unit then raises a busy flag that the pipeline uses to stall. When the operation ends, it posts the result together with a single-cycle done pulse.

Multiplies use a single wide product and finish two cycles after start. Division and remainder use a restoring shift-subtract loop that resolves one quotient bit per clock. The loop works on magnitudes, and the signs are applied in a final cycle. The loop always runs over the widened fixed-point dividend, so every divide-class opcode has the same latency. Opcodes with the top bit set are reserved. They complete at once with a zero result.

Top module: `mdu_top`

## Requirements
- R1: Opcode 4'b0000 returns the low 32 bits of the signed product A*B. Opcode 4'b0001 returns the low 32 bits of the unsigned product.
- R2: Opcode 4'b0010 treats A and B as signed 16.16 values and returns bits [47:16] of their signed 64-bit product.
- R3: Opcodes 4'b0011 (signed) and 4'b0100 (unsigned) return A/B with the quotient truncated toward zero. The signed case -2^31 / -1 returns 32'h8000_0000.
- R4: Opcodes 4'b0110 (signed) and 4'b0111 (unsigned) return A%B. A signed remainder carries the sign of A.
- R5: Opcode 4'b0101 returns the low 32 bits of (A shifted left 16) / B. The division is signed and truncates toward zero.
- R6: When B is zero, the three divide opcodes return 32'hFFFF_FFFF and the two remainder opcodes return A. No other indication is raised.
- R7: With use_imm_i=1, B is imm_i sign-extended to 32 bits and b_reg_i has no effect. With use_imm_i=0, B is b_reg_i and imm_i has no effect.
- R8: If start is accepted in cycle n, done_o is high for exactly cycle n+2 for the multiply opcodes and for exactly cycle n+50 for the divide and remainder opcodes.
- R9: busy_o is high from cycle n+1 up to the cycle before done_o and is low in the done cycle. result_o changes only in a done cycle and holds its value until the next one.
- R10: A start pulse that arrives while busy_o is high is ignored. It changes neither the running operation nor its result.
- R11: Opcodes 4'b1000 to 4'b1111 complete with done_o high in cycle n+1 and a zero result. busy_o never rises for them.
- R12: During and right after reset, busy_o and done_o are low and result_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled while idle |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_reg_i | input | 32 | Register-sourced second operand |
| imm_i | input | 16 | Immediate second operand, sign-extended |
| use_imm_i | input | 1 | Selects imm_i as the second operand |
| busy_o | output | 1 | Operation in flight, stall the pipeline |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Result, held between completions |

## Verification
The bench builds the unit with XLEN=32, FRAC=16 and IMMW=16. With these values the reference model can evaluate every opcode exactly in 64-bit integers, including the 48-bit widened dividend of the fixed-point divide and the -2^31 / -1 overflow. The 48-step divide loop also leaves enough room to hold start high for many busy cycles and to launch a new operation in the very cycle of done, which exposes the acceptance and latency rules.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIN  = 2'd3
    } mdu_state_e;

    localparam logic [3:0] OP_MULS  = 4'b0000;
    localparam logic [3:0] OP_MULU  = 4'b0001;
    localparam logic [3:0] OP_MULFP = 4'b0010;
    localparam logic [3:0] OP_DIVS  = 4'b0011;
    localparam logic [3:0] OP_DIVU  = 4'b0100;
    localparam logic [3:0] OP_DIVFP = 4'b0101;
    localparam logic [3:0] OP_MODS  = 4'b0110;
    localparam logic [3:0] OP_MODU  = 4'b0111;

    function automatic logic op_reserved(input logic [3:0] op);
        return op[3];
    endfunction

    function automatic logic op_is_mul(input logic [3:0] op);
        return (op == OP_MULS) || (op == OP_MULU) || (op == OP_MULFP);
    endfunction

    function automatic logic op_is_quot(input logic [3:0] op);
        return (op == OP_DIVS) || (op == OP_DIVU) || (op == OP_DIVFP);
    endfunction

    function automatic logic op_div_signed(input logic [3:0] op);
        return (op == OP_DIVS) || (op == OP_DIVFP) || (op == OP_MODS);
    endfunction

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep
    import mdu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int FRAC = 16,
    parameter int IMMW = 16,
    localparam int DW  = XLEN + FRAC
) (
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_reg_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            use_imm_i,
    output logic [XLEN-1:0] b_sel_o,
    output logic [XLEN-1:0] b_mag_o,
    output logic [DW-1:0]   dividend_o,
    output logic            neg_q_o,
    output logic            neg_r_o,
    output logic            div_zero_o
);

    logic [XLEN-1:0] b_imm_ext;
    logic [XLEN-1:0] a_mag;
    logic            a_neg;
    logic            b_neg;
    logic            sgn;

    assign b_imm_ext = {{(XLEN-IMMW){imm_i[IMMW-1]}}, imm_i};

    always_comb begin
        b_sel_o    = use_imm_i ? b_imm_ext : b_reg_i;
        sgn        = op_div_signed(op_i);
        a_neg      = sgn & a_i[XLEN-1];
        b_neg      = sgn & b_sel_o[XLEN-1];
        a_mag      = a_neg ? -a_i : a_i;
        b_mag_o    = b_neg ? -b_sel_o : b_sel_o;
        neg_q_o    = a_neg ^ b_neg;
        neg_r_o    = a_neg;
        div_zero_o = (b_sel_o == '0);
        if (op_i == OP_DIVFP) begin
            dividend_o = DW'(a_mag) << FRAC;
        end else begin
            dividend_o = DW'(a_mag);
        end
    end

endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
    parameter int XLEN = 32,
    parameter int FRAC = 16,
    localparam int PW  = XLEN + FRAC
) (
    input  logic            signed_i,
    input  logic            fixed_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o
);

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;
    logic [XLEN-1:0] int_res;
    logic [XLEN-1:0] fix_res;

    always_comb begin
        a_ext = signed_i ? PW'($signed(a_i)) : PW'(a_i);
        b_ext = signed_i ? PW'($signed(b_i)) : PW'(b_i);
        prod  = a_ext * b_ext;
    end

    assign int_res = prod[XLEN-1:0];

    generate
        if (FRAC > 0) begin : g_fix
            assign fix_res = prod[PW-1:FRAC];
        end else begin : g_nofix
            assign fix_res = prod[XLEN-1:0];
        end
    endgenerate

    assign res_o = fixed_i ? fix_res : int_res;

endmodule

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
    parameter int XLEN = 32,
    parameter int DW   = 48
) (
    input  logic [XLEN-1:0] rem_i,
    input  logic [DW-1:0]   quo_i,
    input  logic [XLEN-1:0] div_i,
    output logic [XLEN-1:0] rem_o,
    output logic [DW-1:0]   quo_o
);

    logic [XLEN:0]   shifted;
    logic [XLEN-1:0] diff;
    logic            fits;

    always_comb begin
        shifted = {rem_i, quo_i[DW-1]};
        fits    = shifted >= {1'b0, div_i};
        diff    = shifted[XLEN-1:0] - div_i;
        rem_o   = fits ? diff : shifted[XLEN-1:0];
        quo_o   = {quo_i[DW-2:0], fits};
    end

endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int FRAC = 16,
    parameter int IMMW = 16,
    localparam int DW  = XLEN + FRAC,
    localparam int CW  = $clog2(DW + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_reg_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            use_imm_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);

    typedef struct packed {
        mdu_state_e      state;
        logic [3:0]      op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] rem;
        logic [DW-1:0]   quo;
        logic [CW-1:0]   cnt;
        logic            neg_q;
        logic            neg_r;
        logic            div0;
        logic [XLEN-1:0] result;
        logic            done;
    } mdu_regs_t;

    mdu_regs_t st_d, st_q;

    logic [XLEN-1:0] b_sel;
    logic [XLEN-1:0] b_mag;
    logic [DW-1:0]   dividend;
    logic            neg_q;
    logic            neg_r;
    logic            div_zero;
    logic [XLEN-1:0] mul_res;
    logic [XLEN-1:0] rem_step;
    logic [DW-1:0]   quo_step;
    logic [XLEN-1:0] quo_low;

    mdu_operand_prep #(
        .XLEN(XLEN),
        .FRAC(FRAC),
        .IMMW(IMMW)
    ) prep_i (
        .op_i      (op_i),
        .a_i       (a_i),
        .b_reg_i   (b_reg_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .b_sel_o   (b_sel),
        .b_mag_o   (b_mag),
        .dividend_o(dividend),
        .neg_q_o   (neg_q),
        .neg_r_o   (neg_r),
        .div_zero_o(div_zero)
    );

    mdu_mul #(
        .XLEN(XLEN),
        .FRAC(FRAC)
    ) mul_i (
        .signed_i(st_q.op != OP_MULU),
        .fixed_i (st_q.op == OP_MULFP),
        .a_i     (st_q.a),
        .b_i     (st_q.b),
        .res_o   (mul_res)
    );

    mdu_div_step #(
        .XLEN(XLEN),
        .DW  (DW)
    ) step_i (
        .rem_i(st_q.rem),
        .quo_i(st_q.quo),
        .div_i(st_q.b),
        .rem_o(rem_step),
        .quo_o(quo_step)
    );

    assign quo_low = st_q.quo[XLEN-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.op = op_i;
                    st_d.a  = a_i;
                    if (op_reserved(op_i)) begin
                        st_d.result = '0;
                        st_d.done   = 1'b1;
                    end else if (op_is_mul(op_i)) begin
                        st_d.b     = b_sel;
                        st_d.state = ST_MUL;
                    end else begin
                        st_d.b     = b_mag;
                        st_d.rem   = '0;
                        st_d.quo   = dividend;
                        st_d.cnt   = CW'(DW);
                        st_d.neg_q = neg_q;
                        st_d.neg_r = neg_r;
                        st_d.div0  = div_zero;
                        st_d.state = ST_DIV;
                    end
                end
            end
            ST_MUL: begin
                st_d.result = mul_res;
                st_d.done   = 1'b1;
                st_d.state  = ST_IDLE;
            end
            ST_DIV: begin
                st_d.rem = rem_step;
                st_d.quo = quo_step;
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == CW'(1)) begin
                    st_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                if (op_is_quot(st_q.op)) begin
                    if (st_q.div0) begin
                        st_d.result = '1;
                    end else begin
                        st_d.result = st_q.neg_q ? -quo_low : quo_low;
                    end
                end else begin
                    if (st_q.div0) begin
                        st_d.result = st_q.a;
                    end else begin
                        st_d.result = st_q.neg_r ? -st_q.rem : st_q.rem;
                    end
                end
                st_d.done  = 1'b1;
                st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.state != ST_IDLE);
    assign done_o   = st_q.done;
    assign result_o = st_q.result;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R9

    AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> done_o); // R9

    AST_MUL_TWO_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && op_is_mul(op_i)) |=> busy_o ##1 done_o); // R8

    AST_RSVD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && op_reserved(op_i)) |=> (done_o && !busy_o && result_o == '0)); // R11

    AST_BUSY_HOLDS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ($stable(st_q.op) && $stable(st_q.a))); // R10

    AST_DIV0_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state == ST_FIN && st_q.div0 && op_is_quot(st_q.op)) |=> result_o == '1); // R6

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state == ST_DIV && st_q.b != '0) |-> st_q.rem < st_q.b); // R4

    AST_COUNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state == ST_DIV) |-> (st_q.cnt != '0 && st_q.cnt <= CW'(DW))); // R8

endmodule

// File: tb/mdu_top_tb.sv
module mdu_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int FRAC       = 16;
    localparam int IMMW       = 16;
    localparam int DIV_LAT    = XLEN + FRAC + 2;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b_reg = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] result;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit cmp_en   = 1'b0;
    bit finished = 1'b0;

    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    logic [31:0] m_res  = '0;
    logic [31:0] m_pend = '0;
    int          m_left = 0;
    string       m_tag  = "R12";
    string       m_ptag = "R12";

    always #(CLK_PERIOD/2) clk = ~clk;

    mdu_top #(
        .XLEN(XLEN),
        .FRAC(FRAC),
        .IMMW(IMMW)
    ) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .op_i     (op),
        .a_i      (a),
        .b_reg_i  (b_reg),
        .imm_i    (imm),
        .use_imm_i(use_imm),
        .busy_o   (busy),
        .done_o   (done),
        .result_o (result)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] ref_calc(input logic [3:0] f_op, input logic [31:0] fa, input logic [31:0] fb);
        longint sa = longint'($signed(fa));
        longint sb = longint'($signed(fb));
        longint ua = longint'({32'd0, fa});
        longint ub = longint'({32'd0, fb});
        logic [63:0] p;
        case (f_op)
            4'd0: p = sa * sb;
            4'd1: p = ua * ub;
            4'd2: begin p = sa * sb; return p[47:16]; end
            4'd3: if (sb == 0) p = '1; else p = sa / sb;
            4'd4: if (ub == 0) p = '1; else p = ua / ub;
            4'd5: if (sb == 0) p = '1; else p = (sa <<< FRAC) / sb;
            4'd6: if (sb == 0) p = ua; else p = sa % sb;
            4'd7: if (ub == 0) p = ua; else p = ua % ub;
            default: p = '0;
        endcase
        return p[31:0];
    endfunction

    function automatic string ref_tag(input logic [3:0] f_op, input logic [31:0] fb, input bit f_imm);
        if (f_op[3]) return "R11";
        if (f_op > 4'd2 && fb == 0) return "R6";
        if (f_imm) return "R7";
        case (f_op)
            4'd0, 4'd1: return "R1";
            4'd2: return "R2";
            4'd3, 4'd4: return "R3";
            4'd5: return "R5";
            default: return "R4";
        endcase
    endfunction

    // cycle-level reference model
    always @(posedge clk) begin
        logic [31:0] eff_b;
        cycles++;
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_res = '0; m_left = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_res = m_pend; m_tag = m_ptag;
                end
            end else if (start) begin
                eff_b  = use_imm ? {{16{imm[15]}}, imm} : b_reg;
                m_pend = ref_calc(op, a, eff_b);
                m_ptag = ref_tag(op, eff_b, use_imm);
                if (op[3]) begin
                    m_done = 1'b1; m_res = m_pend; m_tag = m_ptag;
                end else begin
                    m_busy = 1'b1;
                    m_left = (op <= 4'd2) ? 1 : DIV_LAT - 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check(busy === m_busy, "R9", {31'd0, busy}, {31'd0, m_busy});
            check(done === m_done, "R8", {31'd0, done}, {31'd0, m_done});
            check(result === m_res, m_tag, result, m_res);
        end
    end

    task automatic issue(input logic [3:0] t_op, input logic [31:0] ta, input logic [31:0] tb,
                         input bit ti, input logic [15:0] timm);
        op = t_op; a = ta; b_reg = tb; use_imm = ti; imm = timm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R12", {31'd0, busy}, 32'd0);
        check(done === 1'b0, "R12", {31'd0, done}, 32'd0);
        check(result === 32'd0, "R12", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && result === 32'd0, "R12", result, 32'd0);
        cmp_en = 1'b1;

        // R1
        issue(4'd0, 32'hFFFF_FFF9, 32'd6, 1'b0, 16'h0);
        issue(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 16'h0);
        // R2: -1.5 * 2.25
        issue(4'd2, 32'hFFFE_8000, 32'h0002_4000, 1'b0, 16'h0);
        // R3
        issue(4'd3, 32'hFFFF_FFF9, 32'd2, 1'b0, 16'h0);
        issue(4'd3, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 16'h0);
        check(result === 32'h8000_0000, "R3", result, 32'h8000_0000);
        issue(4'd4, 32'hFFFF_FFF9, 32'd2, 1'b0, 16'h0);
        // R4
        issue(4'd6, 32'hFFFF_FFF9, 32'd2, 1'b0, 16'h0);
        check(result === 32'hFFFF_FFFF, "R4", result, 32'hFFFF_FFFF);
        issue(4'd6, 32'd7, 32'hFFFF_FFFE, 1'b0, 16'h0);
        issue(4'd7, 32'hFFFF_FFF9, 32'd10, 1'b0, 16'h0);
        // R5: 1.0 / -4.0
        issue(4'd5, 32'h0001_0000, 32'hFFFC_0000, 1'b0, 16'h0);
        check(result === 32'hFFFF_C000, "R5", result, 32'hFFFF_C000);
        // R6
        issue(4'd3, 32'd123, 32'd0, 1'b0, 16'h0);
        check(result === 32'hFFFF_FFFF, "R6", result, 32'hFFFF_FFFF);
        issue(4'd7, 32'hDEAD_BEEF, 32'd0, 1'b0, 16'h0);
        check(result === 32'hDEAD_BEEF, "R6", result, 32'hDEAD_BEEF);
        issue(4'd5, 32'd9, 32'd0, 1'b0, 16'h0);
        // R7: immediate -3 with junk register operand, then junk immediate ignored
        issue(4'd0, 32'd5, 32'h1234_5678, 1'b1, 16'hFFFD);
        check(result === 32'hFFFF_FFF1, "R7", result, 32'hFFFF_FFF1);
        issue(4'd4, 32'd100, 32'd7, 1'b0, 16'h8001);
        check(result === 32'd14, "R7", result, 32'd14);
        // R11: reserved, back-to-back from done cycle
        issue(4'd8, 32'd5, 32'd5, 1'b0, 16'h0);
        issue(4'd15, 32'd5, 32'd5, 1'b0, 16'h0);
        check(result === 32'd0, "R11", result, 32'd0);
        // R10: start held high while busy with different operands
        op = 4'd4; a = 32'd1000; b_reg = 32'd7; use_imm = 1'b0; start = 1'b1;
        @(negedge clk);
        op = 4'd0; a = 32'd3; b_reg = 32'd3;
        repeat (10) @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(result === 32'd142, "R10", result, 32'd142);

        // mixed traffic
        for (int i = 0; i < 60; i++) begin
            logic [31:0] rb;
            rb = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 9)) : $urandom;
            issue(4'($urandom_range(0, 9)), $urandom, rb, 1'($urandom_range(0, 1)), 16'($urandom));
        end
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > WATCHDOG);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R8 watchdog expired actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule